// File: doc/BRIEF.md
# Depth-Cascadable FIFO with Token Hand-Off

This block is a 9-bit-wide first-in first-out queue. It is built from a two-port storage array, a write pointer and a read pointer, and it reports its fill state through three active-low, registered flags: empty, more-than-half and full. A write and a read can both be accepted in the same clock cycle. Read data is presented on a data bus together with an output-enable. The enable models a tri-state driver, so several instances can share one bus.

Several instances can be chained into one deeper queue. All instances share the write strobe, the read strobe and the input data. Each instance owns a write token and a read token. When an instance performs an accepted write or read on its top physical location, it drops its expansion output low for that cycle. The next instance in the ring samples this on its expansion input, together with the active strobe, and takes over the matching token. The instance whose first-load input is high holds both tokens after master reset.

A standalone instance ties its expansion output back to its own expansion input. A retransmit input rewinds the read pointer to location zero.

A pulse carries no token identity. In a chain of more than one instance, the cycle in which a token changes hands must therefore not carry both strobes at once.

Top module: `token_fifo`

## Requirements
- R1: While `mr_n` is low, `empty_n`=0, `half_n`=1, `full_n`=1, `dout_oe`=0 and `xout_n`=1. Strobes seen during reset store nothing, and the queue is empty after release.
- R2: Words leave in the order they were accepted. An accepted read drives the word on `dout` with `dout_oe`=1 in the cycle after the edge. `dout_oe` is 0 in every other cycle. A write and a read in the same cycle are both accepted.
- R3: Each flag is registered. `empty_n` is 0 exactly when the occupancy is 0. `half_n` is 0 exactly when the occupancy exceeds DEPTH/2. `full_n` is 0 exactly when the occupancy equals DEPTH.
- R4: A write while full and a read while empty are ignored. An ignored read leaves `dout_oe` at 0.
- R5: `xout_n` is low, combinationally, in the cycle of an accepted write or read to location DEPTH-1. It is high otherwise.
- R6: `first_load`=1 during reset gives the instance both tokens, and 0 gives it none. Without the write token, write strobes are ignored. Without the read token, read strobes are ignored.
- R7: An edge with `xin_n`=0 grants the write token if `wr_n`=0 and grants the read token if `rd_n`=0. Passing a token clears it, and a grant in the same edge wins.
- R8: `rt`=1 with both strobes inactive moves the read pointer to 0 and sets the occupancy to the write-pointer value. The flags follow this new occupancy. `rt` has no effect while either strobe is active.
- R9: Both pointers wrap from DEPTH-1 to 0, and operation continues across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mr_n | input | 1 | Master reset, active low, asynchronous |
| first_load | input | 1 | Owns both tokens after reset when high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt | input | 1 | Retransmit (read pointer rewind) |
| din | input | W | Write data |
| xin_n | input | 1 | Expansion input, active low |
| xout_n | output | 1 | Expansion output, active low |
| dout | output | W | Read data |
| dout_oe | output | 1 | Read data valid / bus drive enable |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | More-than-half flag, active low |
| full_n | output | 1 | Full flag, active low |

## Verification
The bench builds two configurations:

- **Standalone, DEPTH 8.** One instance has its expansion output looped to its own input. Full, half, the pointer wrap and self-hand-off are all a few writes away. A reference queue model is checked every cycle through a long pseudo-random mix of writes, reads and rewinds.
- **Two-instance ring, DEPTH 4.** Both directions of write-token and read-token hand-off are reached within six words. Data order is checked across the shared bus. The bench also shows that the instance without a token leaves its flags and bus untouched.

// File: rtl/token_fifo.sv
`timescale 1ns/1ps
module token_fifo #(
  parameter int W = 9,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         mr_n,
  input  logic         first_load,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic         rt,
  input  logic [W-1:0] din,
  input  logic         xin_n,
  output logic         xout_n,
  output logic [W-1:0] dout,
  output logic         dout_oe,
  output logic         empty_n,
  output logic         half_n,
  output logic         full_n
);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULLC = (AW+1)'(DEPTH);
  localparam logic [AW:0]   HALFC = (AW+1)'(DEPTH / 2);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt, cnt_nx;
  logic          wtok, rtok;

  wire wr_go  = mr_n && !wr_n && wtok && (cnt != FULLC);
  wire rd_go  = mr_n && !rd_n && rtok && (cnt != '0);
  wire rewind = rt && wr_n && rd_n;
  wire w_last = wr_go && (wptr == LAST);
  wire r_last = rd_go && (rptr == LAST);

  assign xout_n = !(w_last || r_last);

  always_comb begin
    if (rewind) cnt_nx = {1'b0, wptr};
    else        cnt_nx = cnt + (AW+1)'(wr_go) - (AW+1)'(rd_go);
  end

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      wtok    <= first_load;
      rtok    <= first_load;
      dout_oe <= 1'b0;
      empty_n <= 1'b0;
      half_n  <= 1'b1;
      full_n  <= 1'b1;
    end else begin
      if (wr_go) wptr <= wptr + 1'b1;
      if (rewind)     rptr <= '0;
      else if (rd_go) rptr <= rptr + 1'b1;
      cnt     <= cnt_nx;
      wtok    <= (wtok && !w_last) || (!xin_n && !wr_n);
      rtok    <= (rtok && !r_last) || (!xin_n && !rd_n);
      dout_oe <= rd_go;
      empty_n <= (cnt_nx != '0);
      half_n  <= !(cnt_nx > HALFC);
      full_n  <= (cnt_nx != FULLC);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rd_go) dout <= mem[rptr];
  end
endmodule

// File: rtl/token_fifo_chk.sv
`timescale 1ns/1ps
module token_fifo_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          mr_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          rt,
  input logic          empty_n,
  input logic          half_n,
  input logic          full_n,
  input logic          dout_oe,
  input logic          wtok,
  input logic [AW-1:0] wptr
);
  a_r3_full_implies_half: assert property (@(posedge clk) disable iff (!mr_n)
    !full_n |-> !half_n);

  a_r3_empty_excludes_rest: assert property (@(posedge clk) disable iff (!mr_n)
    !empty_n |-> (half_n && full_n));

  a_r4_full_holds: assert property (@(posedge clk) disable iff (!mr_n)
    (!full_n && rd_n && !rt) |=> !full_n);

  a_r4_empty_holds: assert property (@(posedge clk) disable iff (!mr_n)
    (!empty_n && wr_n && !rt) |=> !empty_n);

  a_r2_oe_follows_read: assert property (@(posedge clk) disable iff (!mr_n)
    dout_oe |-> $past(!rd_n));

  a_r6_no_token_no_write: assert property (@(posedge clk) disable iff (!mr_n)
    !wtok |=> $stable(wptr));
endmodule

bind token_fifo token_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .mr_n(mr_n), .wr_n(wr_n), .rd_n(rd_n), .rt(rt),
  .empty_n(empty_n), .half_n(half_n), .full_n(full_n),
  .dout_oe(dout_oe), .wtok(wtok), .wptr(wptr)
);

// File: tb/sim_token_fifo.sv
`timescale 1ns/1ps
module sim_token_fifo;
  localparam int D0 = 8;
  localparam int D1 = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic mr_n = 1'b0;
  logic w0_n = 1'b1, r0_n = 1'b1, rt0 = 1'b0;
  logic [8:0] di0 = '0, do0;
  logic oe0, xo0, e0, h0, f0;

  token_fifo #(.W(9), .DEPTH(D0)) u0 (
    .clk(clk), .mr_n(mr_n), .first_load(1'b1), .wr_n(w0_n), .rd_n(r0_n),
    .rt(rt0), .din(di0), .xin_n(xo0), .xout_n(xo0), .dout(do0),
    .dout_oe(oe0), .empty_n(e0), .half_n(h0), .full_n(f0));

  logic cw_n = 1'b1, cr_n = 1'b1;
  logic [8:0] cdi = '0, do1, do2;
  logic oe1, oe2, xo1, xo2, e1, h1, f1, e2, h2, f2;

  token_fifo #(.W(9), .DEPTH(D1)) u1 (
    .clk(clk), .mr_n(mr_n), .first_load(1'b1), .wr_n(cw_n), .rd_n(cr_n),
    .rt(1'b0), .din(cdi), .xin_n(xo2), .xout_n(xo1), .dout(do1),
    .dout_oe(oe1), .empty_n(e1), .half_n(h1), .full_n(f1));

  token_fifo #(.W(9), .DEPTH(D1)) u2 (
    .clk(clk), .mr_n(mr_n), .first_load(1'b0), .wr_n(cw_n), .rd_n(cr_n),
    .rt(1'b0), .din(cdi), .xin_n(xo1), .xout_n(xo2), .dout(do2),
    .dout_oe(oe2), .empty_n(e2), .half_n(h2), .full_n(f2));

  int nchk = 0, nfail = 0;
  int mcnt, mw, mr;
  logic [8:0] mm [D0];
  logic [15:0] lf = 16'hACE1;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_all();
    @(negedge clk);
    mr_n = 1'b0; w0_n = 1'b0; cw_n = 1'b0; r0_n = 1'b1; cr_n = 1'b1; rt0 = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 empty_n in reset", int'(e0), 0);
    check("R1 half_n in reset", int'(h0), 1);
    check("R1 full_n in reset", int'(f0), 1);
    check("R1 dout_oe in reset", int'(oe0), 0);
    check("R1 xout_n in reset", int'(xo0), 1);
    @(negedge clk);
    w0_n = 1'b1; cw_n = 1'b1;
    @(negedge clk);
    mr_n = 1'b1;
    mcnt = 0; mw = 0; mr = 0;
  endtask

  task automatic step0(input string tag, input bit w, input bit r, input bit t,
                       input logic [8:0] d);
    bit wok, rok;
    logic [8:0] ed;
    ed = '0;
    @(negedge clk);
    w0_n = !w; r0_n = !r; rt0 = t; di0 = d;
    wok = w && (mcnt < D0);
    rok = r && (mcnt > 0);
    #1 check({tag, " R5 xout_n"}, int'(xo0),
             int'(!((wok && mw == D0-1) || (rok && mr == D0-1))));
    @(posedge clk);
    if (rok) begin ed = mm[mr]; mr = (mr + 1) % D0; end
    if (wok) begin mm[mw] = d; mw = (mw + 1) % D0; end
    mcnt = mcnt + int'(wok) - int'(rok);
    if (t && !w && !r) begin mr = 0; mcnt = mw; end
    #2;
    check({tag, " R3 empty_n"}, int'(e0), int'(mcnt != 0));
    check({tag, " R3 half_n"}, int'(h0), int'(!(mcnt > D0/2)));
    check({tag, " R3 full_n"}, int'(f0), int'(mcnt != D0));
    check({tag, " R4 dout_oe"}, int'(oe0), int'(rok));
    if (rok) check({tag, " R2 dout"}, int'(do0), int'(ed));
  endtask

  task automatic stepc(input bit w, input bit r, input logic [8:0] d,
                       output logic x1, output logic x2);
    @(negedge clk);
    cw_n = !w; cr_n = !r; cdi = d;
    #1 x1 = xo1; x2 = xo2;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic x1, x2;
    logic [8:0] bus;
    reset_all();
    step0("R1", 0, 0, 0, 9'd0);

    // chain: u1 owns tokens, u2 none
    check("R6 u2 empty after reset", int'(e2), 0);
    for (int i = 0; i < 6; i++) begin
      stepc(1, 0, 9'(10 + i), x1, x2);
      if (i == 2) check("R6 u2 ignores writes without token", int'(e2), 0);
      if (i == 3) check("R5 u1 xout_n on last write", int'(x1), 0);
      if (i == 4) check("R7 u2 took write token", int'(e2), 1);
    end
    check("R3 u1 full", int'(f1), 0);
    check("R3 u2 not empty", int'(e2), 1);
    check("R3 u2 not half at 2 of 4", int'(h2), 1);
    check("R3 u2 not full", int'(f2), 1);
    for (int i = 0; i < 6; i++) begin
      stepc(0, 1, 9'd0, x1, x2);
      check("R2 single bus driver", int'(oe1) + int'(oe2), 1);
      bus = oe1 ? do1 : do2;
      check("R2 chain read order", int'(bus), 10 + i);
      if (i == 3) begin
        check("R7 u1 passes read token", int'(x1), 0);
        check("R3 u1 empty after 4 reads", int'(e1), 0);
      end
    end
    check("R3 u2 empty after 6 reads", int'(e2), 0);
    stepc(1, 0, 9'd20, x1, x2);
    stepc(1, 0, 9'd21, x1, x2);
    check("R9 u2 xout_n at wrap write", int'(x2), 0);
    check("R6 u1 unchanged before token return", int'(e1), 0);
    stepc(1, 0, 9'd22, x1, x2);
    check("R7 write token back at u1", int'(e1), 1);
    for (int i = 0; i < 3; i++) begin
      stepc(0, 1, 9'd0, x1, x2);
      bus = oe1 ? do1 : do2;
      check("R7 order across read hand-off", int'(bus), 20 + i);
      check("R2 single driver after hand-off", int'(oe1) + int'(oe2), 1);
    end
    stepc(0, 1, 9'd0, x1, x2);
    check("R4 chain read while empty", int'(oe1) + int'(oe2), 0);
    stepc(0, 0, 9'd0, x1, x2);

    // standalone: fill past full, drain past empty
    for (int i = 0; i < D0 + 2; i++) step0("R4 fill", 1, 0, 0, 9'(100 + i));
    for (int i = 0; i < D0 + 2; i++) step0("R4 drain", 0, 1, 0, 9'd0);
    for (int i = 0; i < 5; i++) step0("R2 both", 1, 1, 0, 9'(200 + i));

    // rewind
    reset_all();
    for (int i = 0; i < 5; i++) step0("R8 load", 1, 0, 0, 9'(300 + i));
    for (int i = 0; i < 3; i++) step0("R8 pre", 0, 1, 0, 9'd0);
    step0("R8 rewind idle", 0, 0, 1, 9'd0);
    for (int i = 0; i < 6; i++) step0("R8 replay", 0, 1, 0, 9'd0);
    step0("R8 rewind with write", 1, 0, 1, 9'd77);
    step0("R8 rewind with read", 0, 1, 1, 9'd0);

    // pseudo-random sweep with wrap-around
    for (int i = 0; i < 3000; i++) begin
      bit w, r, t;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if ((i / 150) % 2 == 0) begin
        w = lf[0] | lf[1]; r = lf[2] & lf[3];
      end else begin
        w = lf[0] & lf[1]; r = lf[2] | lf[3];
      end
      t = (lf[9:6] == 4'd0);
      step0("R9 sweep", w, r, t, 9'(lf[15:7]));
    end
    step0("R9 idle", 0, 0, 0, 9'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule